// File: doc/BRIEF.md
# Paged Control-Register Access over I2C

This block is an I2C target that lets a host read and write a bank of 8-bit control registers. The bank is split into four pages. A page-select register can be reached at the same address on every page, so the host can always move between pages. The block matches a 7-bit bus address. Five of its bits are fixed and two come from strap inputs, so up to four of these blocks can share one bus.

After its bus address with the write direction, the host sends a pointer byte. Bits 6:0 of that byte are the register address. Bit 7 chooses whether the pointer steps forward after each data byte. Data bytes that follow are written at the pointer. To read, the host issues a repeated START with the read direction. Read data then comes from the current pointer and keeps coming until the host answers a byte with NACK.

Both bus lines are oversampled by the system clock. START and STOP are recognised as a change on SDA while SCL is high. The block drives SDA only through an active-high pull-down enable.

Top module: `i2c_page_regs`

## Requirements
- R1: The block acknowledges only the bus address whose bits 7:3 are 11100 and whose bits 2:1 equal `strap_i`, with bit 0 as the direction (0 write, 1 read). For any other address it drives nothing, and the bytes that follow in that transfer change no register.
- R2: After a matching address byte and after every byte the host writes, the block pulls SDA low for the acknowledge clock.
- R3: The first byte after a write address is the pointer byte. Its bits 6:0 become the register pointer and its bit 7 becomes the step flag, where 1 means step.
- R4: With the step flag set, each data byte written or read moves the pointer up by one. The pointer wraps from 0x7F to 0x00, and that wrap takes effect together with a page change made by the same byte.
- R5: With the step flag clear, every data byte is written to the same address, and a read burst returns the same address each time.
- R6: Address 0x7F selects the page on every page. It stores bits 1:0 of the written byte and reads back with bits 7:2 as zero. Each page has its own storage at addresses 0x00 to 0x07, and `page_o` shows the selected page.
- R7: Address 0x7E returns `status_i` on every page. A write there is acknowledged and has no effect.
- R8: Every other address reads as 0x00. Writes to such an address are acknowledged and have no effect.
- R9: A repeated START followed by the read address returns data starting at the pointer that the previous pointer byte left, or that the previous transfer advanced it to.
- R10: In a read burst, a host ACK makes the block send the next byte. A host NACK ends the burst, and SDA is released before the next START or STOP.
- R11: A START at any bit position, including in the middle of a byte, restarts address reception with no partial write. A STOP returns the block to idle with SDA released.
- R12: After reset the page is 0, SDA is released and every storage register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Strap bits that form bits 2:1 of the bus address |
| status_i | input | 8 | Read-only status value returned at address 0x7E |
| sda_oe_o | output | 1 | Active-high enable that pulls SDA low |
| page_o | output | 2 | Currently selected register page |

## Verification
Two functions can fall on the same clock edge: the page-select write and the pointer wrap. A byte written to 0x7F with the step flag set updates the page register and wraps the pointer to 0x00 on the same edge. The byte after it must therefore land in register 0 of the newly selected page. The bench provokes this with a pointer byte of 0xFF followed by two data bytes. Its behavioural model applies the page change first and then the wrapped write. The result is judged through a stepping read from 0xFF, which returns the page value and then the new page's register 0, and through a later read of the other page, which must be unchanged.

// File: rtl/i2c_pr_pkg.sv
package i2c_pr_pkg;

  // fixed upper bits of the bus address; bits 2:1 come from straps
  localparam logic [4:0] DEV_PREFIX    = 5'b11100;
  localparam logic [6:0] PAGE_SEL_ADDR = 7'h7F;
  localparam logic [6:0] STATUS_ADDR   = 7'h7E;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_AW,
    ST_ACK_AR,
    ST_PTR,
    ST_ACK_PTR,
    ST_WDATA,
    ST_ACK_WD,
    ST_RDATA,
    ST_RACK
  } bus_state_e;

endpackage

// File: rtl/i2c_pr_sync.sv
module i2c_pr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sync_n,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic [SYNC_STAGES-1:0] scl_pipe_q;
  logic [SYNC_STAGES-1:0] sda_pipe_q;
  logic                   scl_last_q;
  logic                   sda_last_q;

  // reset asserts at once and releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // an idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      scl_last_q <= scl_s;
      sda_last_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s     = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_last_q;
  assign scl_fall  = ~scl_s & scl_last_q;
  assign start_det = scl_s & scl_last_q & sda_last_q & ~sda_s;
  assign stop_det  = scl_s & scl_last_q & ~sda_last_q & sda_s;

endmodule

// File: rtl/i2c_pr_engine.sv
module i2c_pr_engine
  import i2c_pr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] strap_i,
  input  logic [7:0] rd_data_i,
  output logic [6:0] ptr_o,
  output logic       auto_inc_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  bus_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [6:0] ptr_q, ptr_d;
  logic       inc_q, inc_d;
  logic       oe_q, oe_d;
  logic       mack_q, mack_d;
  logic       addr_hit;

  assign addr_hit = (sh_q[7:1] == {DEV_PREFIX, strap_i});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    inc_d   = inc_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    wr_en_o = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && cnt_q != BITS_PER_BYTE) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BITS_PER_BYTE) begin
            cnt_d = 4'd0;
            case (state_q)
              ST_ADDR: begin
                if (addr_hit) begin
                  oe_d    = 1'b1;
                  state_d = sh_q[0] ? ST_ACK_AR : ST_ACK_AW;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              ST_PTR: begin
                ptr_d   = sh_q[6:0];
                inc_d   = sh_q[7];
                oe_d    = 1'b1;
                state_d = ST_ACK_PTR;
              end
              default: begin
                wr_en_o = 1'b1;
                if (inc_q) ptr_d = ptr_q + 7'd1;
                oe_d    = 1'b1;
                state_d = ST_ACK_WD;
              end
            endcase
          end
        end
        ST_ACK_AW, ST_ACK_PTR, ST_ACK_WD: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = (state_q == ST_ACK_AW) ? ST_PTR : ST_WDATA;
          end
        end
        ST_ACK_AR: begin
          if (scl_fall) begin
            sh_d    = rd_data_i;
            oe_d    = ~rd_data_i[7];
            cnt_d   = 4'd0;
            state_d = ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BITS_PER_BYTE) begin
              oe_d    = 1'b0;
              if (inc_q) ptr_d = ptr_q + 7'd1;
              state_d = ST_RACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[7];
              cnt_d   = 4'd0;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'd0;
      ptr_q   <= 7'd0;
      inc_q   <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      inc_q   <= inc_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign auto_inc_o = inc_q;
  assign wr_data_o  = sh_q;
  assign sda_oe_o   = oe_q;

endmodule

// File: rtl/i2c_pr_regfile.sv
module i2c_pr_regfile
  import i2c_pr_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int NUM_REGS  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [6:0]                    addr_i,
  input  logic [7:0]                    wr_data_i,
  input  logic [7:0]                    status_i,
  output logic [7:0]                    rd_data_o,
  output logic [$clog2(NUM_PAGES)-1:0]  page_o
);

  localparam int         PAGE_W  = $clog2(NUM_PAGES);
  localparam int         FLAT_W  = NUM_PAGES * NUM_REGS * 8;
  localparam logic [6:0] REG_LIM = 7'(NUM_REGS);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [FLAT_W-1:0] flat;
  int                rd_idx;

  // page select register
  always_comb begin
    page_d = page_q;
    if (wr_en_i && addr_i == PAGE_SEL_ADDR) page_d = wr_data_i[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  // per-page storage, one byte per page and address
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [PAGE_W-1:0] PG = PAGE_W'(p);
      localparam logic [6:0]        RA = 7'(r);
      logic       hit;
      logic [7:0] byte_q;
      assign hit = wr_en_i && (page_q == PG) && (addr_i == RA);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   byte_q <= 8'd0;
        else if (hit) byte_q <= wr_data_i;
      end
      assign flat[(p*NUM_REGS + r)*8 +: 8] = byte_q;
    end
  end

  always_comb begin
    rd_idx    = int'(page_q) * NUM_REGS + int'(addr_i);
    rd_data_o = 8'd0;
    if (addr_i == PAGE_SEL_ADDR) begin
      rd_data_o[PAGE_W-1:0] = page_q;
    end else if (addr_i == STATUS_ADDR) begin
      rd_data_o = status_i;
    end else if (addr_i < REG_LIM) begin
      rd_data_o = flat[rd_idx*8 +: 8];
    end
  end

  assign page_o = page_q;

endmodule

// File: rtl/i2c_page_regs.sv
module i2c_page_regs #(
  parameter int NUM_PAGES   = 4,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic [1:0]                    strap_i,
  input  logic [7:0]                    status_i,
  output logic                          sda_oe_o,
  output logic [$clog2(NUM_PAGES)-1:0]  page_o
);

  localparam int PAGE_W = $clog2(NUM_PAGES);

  logic       rst_sync_n;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic [6:0] reg_ptr;
  logic       auto_inc;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [PAGE_W-1:0] page;

  i2c_pr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .rst_sync_n (rst_sync_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det)
  );

  i2c_pr_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_s      (sda_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data),
    .ptr_o      (reg_ptr),
    .auto_inc_o (auto_inc),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_pr_regfile #(.NUM_PAGES(NUM_PAGES), .NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .addr_i    (reg_ptr),
    .wr_data_i (wr_data),
    .status_i  (status_i),
    .rd_data_o (rd_data),
    .page_o    (page)
  );

  assign page_o = page;

endmodule

// File: rtl/i2c_page_regs_chk.sv
module i2c_page_regs_chk #(
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_det,
  input logic              sda_oe,
  input logic [PAGE_W-1:0] page,
  input logic              wr_en,
  input logic [6:0]        ptr,
  input logic              inc
);

  // R6
  page_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page) |-> $past(wr_en && ptr == 7'h7F));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  oe_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inc) |=> ptr == $past(ptr) + 7'd1);

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inc) |=> $stable(ptr));

endmodule

bind i2c_page_regs i2c_page_regs_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .sda_oe   (sda_oe_o),
  .page     (page),
  .wr_en    (wr_en),
  .ptr      (reg_ptr),
  .inc      (auto_inc)
);

// File: tb/i2c_page_regs_tb.sv
module i2c_page_regs_tb;

  localparam int         Q   = 10;
  localparam logic [6:0] DEV = {5'b11100, 2'b10};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic [1:0] strap;
  logic [7:0] stat_v;
  logic       sda_oe;
  logic [1:0] page;
  wire        sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_page_regs u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .status_i (stat_v),
    .sda_oe_o (sda_oe),
    .page_o   (page)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit settled = 1'b0;
  bit done = 1'b0;

  // behavioural model of the register space
  logic [7:0] mdl_mem [4][8];
  int         mdl_page;
  int         mdl_ptr;
  bit         mdl_inc;
  logic [7:0] wq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    if (a == 127) return mdl_page;
    if (a == 126) return int'(stat_v);
    if (a < 8)    return int'(mdl_mem[mdl_page][a]);
    return 0;
  endfunction

  task automatic mdl_wr(input int a, input logic [7:0] d);
    if (a == 127)   mdl_page = int'(d[1:0]);
    else if (a < 8) mdl_mem[mdl_page][a] = d;
  endtask

  task automatic mdl_step();
    if (mdl_inc) mdl_ptr = (mdl_ptr + 1) % 128;
  endtask

  // per-clock comparison while the bus is quiet
  always @(negedge clk) begin
    if (settled && !done) begin
      chk(int'(page) == mdl_page, "R6 page_o vs model", int'(page), mdl_page);
      chk(sda_oe == 1'b0, "R11 sda released on idle bus", int'(sda_oe), 0);
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
    hq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hq();
    scl_m = 1'b1; hq();
    s = sda_line; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!mack, s);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] ptrb, input string req);
    bit a;
    settled = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 own address acked", int'(a), 1);
    send_byte(ptrb, a);        chk(a, "R2 pointer byte acked", int'(a), 1);
    mdl_ptr = int'(ptrb[6:0]);
    mdl_inc = ptrb[7];
    foreach (wq[i]) begin
      send_byte(wq[i], a);
      chk(a, {req, " R2 data byte acked"}, int'(a), 1);
      mdl_wr(mdl_ptr, wq[i]);
      mdl_step();
    end
    bus_stop();
    wq.delete();
    settled = 1'b1;
  endtask

  task automatic read_tail(input int n, input string req);
    logic [7:0] b;
    int e;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      e = exp_rd(mdl_ptr);
      chk(int'(b) == e, req, int'(b), e);
      mdl_step();
    end
    chk(sda_oe == 1'b0, "R10 sda released after NACK", int'(sda_oe), 0);
    bus_stop();
    settled = 1'b1;
  endtask

  // pointer byte, repeated START, read burst
  task automatic do_read(input logic [7:0] ptrb, input int n, input string req);
    bit a;
    settled = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 own address acked", int'(a), 1);
    send_byte(ptrb, a);        chk(a, "R2 pointer byte acked", int'(a), 1);
    mdl_ptr = int'(ptrb[6:0]);
    mdl_inc = ptrb[7];
    bus_rstart();
    send_byte({DEV, 1'b1}, a); chk(a, "R9 read address acked", int'(a), 1);
    read_tail(n, req);
  endtask

  // read from the pointer left by earlier transfers
  task automatic do_read_cur(input int n, input string req);
    bit a;
    settled = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, a); chk(a, "R9 read address acked", int'(a), 1);
    read_tail(n, req);
  endtask

  initial begin
    bit a;
    logic s;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 2'b10; stat_v = 8'h3C;
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 8; r++) mdl_mem[p][r] = 8'h00;
    mdl_page = 0; mdl_ptr = 0; mdl_inc = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R12 reset state
    chk(page == 2'd0, "R12 page after reset", int'(page), 0);
    chk(sda_oe == 1'b0, "R12 sda released after reset", int'(sda_oe), 0);
    settled = 1'b1;
    do_read(8'h80, 8, "R12 storage zero after reset");

    // R1 foreign address: no ack, no effect
    settled = 1'b0;
    bus_start();
    send_byte({5'b11100, 2'b01, 1'b0}, a); chk(!a, "R1 foreign address not acked", int'(a), 0);
    send_byte(8'h80, a); chk(!a, "R1 no ack after foreign address", int'(a), 0);
    send_byte(8'h55, a); chk(!a, "R1 no ack after foreign address", int'(a), 0);
    bus_stop();
    settled = 1'b1;
    do_read(8'h80, 2, "R1 foreign write changed nothing");

    // R3 R4 stepping write and read
    wq = '{8'hA1, 8'hA2, 8'hA3};
    do_write(8'h82, "R4 stepping write");
    do_read(8'h81, 5, "R4 R3 stepping readback");

    // R5 fixed address
    wq = '{8'h11, 8'h22, 8'h33};
    do_write(8'h05, "R5 fixed-address write");
    do_read(8'h85, 2, "R5 only last byte kept");
    do_read(8'h02, 3, "R5 read repeats one address");

    // R6 pages
    wq = '{8'h02};
    do_write(8'h7F, "R6 select page 2");
    chk(page == 2'd2, "R6 page_o shows 2", int'(page), 2);
    wq = '{8'h99, 8'h98};
    do_write(8'h80, "R6 page 2 write");
    do_read(8'h7F, 1, "R6 page select on page 2");
    do_read(8'h80, 3, "R6 page 2 contents");
    wq = '{8'hFF};
    do_write(8'h7F, "R6 select page 3");
    do_read(8'h7F, 1, "R6 upper bits read zero");
    wq = '{8'h00};
    do_write(8'h7F, "R6 back to page 0");
    do_read(8'h80, 6, "R6 page 0 untouched");

    // R7 status
    do_read(8'h7E, 1, "R7 status read");
    wq = '{8'h00};
    do_write(8'h7E, "R7 status write");
    stat_v = 8'hA5;
    do_read(8'h7E, 1, "R7 status follows input");
    wq = '{8'h01};
    do_write(8'h7F, "R7 move to page 1");
    do_read(8'h7E, 1, "R7 status on page 1");

    // R8 unimplemented
    wq = '{8'h77, 8'h66};
    do_write(8'hC0, "R8 unimplemented write");
    do_read(8'hC0, 2, "R8 unimplemented reads zero");
    do_read(8'h80, 8, "R8 storage unchanged");

    // R4 R6 page change and pointer wrap on one byte
    wq = '{8'h03, 8'h5A};
    do_write(8'hFF, "R4 wrap with page change");
    do_read(8'hFF, 3, "R4 wrap readback");
    wq = '{8'h01};
    do_write(8'h7F, "R6 return to page 1");
    do_read(8'h80, 2, "R6 page 1 untouched by wrap");

    // R9 read continues from pointer
    wq = '{8'hC1, 8'hC2, 8'hC3};
    do_write(8'h84, "R9 setup");
    do_read(8'h84, 1, "R9 read from pointer byte");
    do_read_cur(2, "R9 read continues from pointer");

    // R10 burst length follows host ack
    do_read(8'h80, 7, "R10 long burst");

    // R11 START in mid-byte aborts; STOP in mid-byte idles
    settled = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R11 address acked", int'(a), 1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_rstart();
    send_byte({DEV, 1'b0}, a); chk(a, "R11 address acked after restart", int'(a), 1);
    send_byte(8'h03, a);       chk(a, "R11 pointer acked after restart", int'(a), 1);
    send_byte(8'h42, a);       chk(a, "R11 data acked after restart", int'(a), 1);
    mdl_ptr = 3; mdl_inc = 1'b0; mdl_wr(3, 8'h42);
    bus_stop();
    settled = 1'b1;
    do_read(8'h80, 8, "R11 only restarted write landed");
    settled = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R11 address acked", int'(a), 1);
    send_byte(8'h80, a);       chk(a, "R11 pointer acked", int'(a), 1);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    settled = 1'b1;
    hq();
    do_read(8'h80, 8, "R11 partial byte before STOP wrote nothing");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R11 bus run did not finish actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule